// File: doc/BRIEF.md
# Shared Memory Round-Robin Controller

This block lets three client ports share one single-port memory with 16-bit addresses and 16-bit data. Each client gets a port that looks like a private memory. A client raises its chip select together with a read or write strobe, an address and write data. It then waits for its ready flag, which marks the operation as done. The controller picks one waiting client by round-robin rotation and puts that client's address, data and strobes on the memory-side port for one access cycle. In the next cycle it returns the memory's read data to that client and raises the client's ready flag.

The client side works as a request/response handshake. Chip select acts as the request valid. The client must keep chip select, the strobes, the address and the write data steady until the clock edge that ends its ready cycle. A client that is not being served sees ready low, and that back-pressure is all it gets. The memory must return read data one cycle after it is accessed. Only one access is in flight at a time, so the shared memory carries at most one access every two cycles.

Top module: `shmem_rr_ctrl`

## Requirements
- R1: While the active-low reset is low and immediately after it rises, memory-side chip select, read and write are 0, every client ready bit is 0 and every client read-data word is 0.
- R2: If any client holds chip select high during an idle cycle, the next cycle is an access cycle. In an access cycle memory chip select is 1 and the memory address, write data, read strobe and write strobe equal those of the granted client. In every other cycle memory chip select, read and write are 0.
- R3: For a read, the granted client's ready bit (bit i for client i) is 1 in the cycle after its access cycle. In that same cycle its read-data word equals the memory read data.
- R4: For a write, the granted client's ready bit is 1 in the cycle after its access cycle and its read-data word is 0. A client's read-data word is 0 in every cycle where it is not receiving a read response.
- R5: At most one access is in flight, so memory chip select is never 1 in two consecutive cycles. A sole client that holds chip select high through its ready cycle gets an access every third cycle.
- R6: After reset the rotation pointer selects client 0 first. A grant goes to the first requesting client found by searching from the pointer in cyclic order 0, 1, 2, 0.
- R7: After a grant the pointer moves to the client after the one served, with client 0 following client 2. While no client requests, the pointer keeps its value.
- R8: A client that is not granted sees its ready bit at 0 and keeps waiting. A client that keeps chip select high is served again only after every other client that was waiting has had one turn.
- R9: When reset goes low during an access, memory chip select, read and write and every client ready bit go to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cli_cs | input | 3 | Per-client request (chip select), bit i for client i |
| cli_rd | input | 3 | Per-client read strobe |
| cli_wr | input | 3 | Per-client write strobe |
| cli_addr | input | 3x16 | Per-client address, packed with client i in slice i |
| cli_wdata | input | 3x16 | Per-client write data |
| cli_rdata | output | 3x16 | Per-client read data, valid with its ready bit on a read |
| cli_rdy | output | 3 | Per-client completion flag |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the access |
| mem_cs | output | 1 | Memory chip select |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
A wrong grant register or rotation pointer shows up as a wrong client index on the memory-side address and in the order of the ready bits. That order differs from the expected one already at the second grant of a multi-client burst. A phase register that is stuck or skips a state shows at once as chip select high in two consecutive cycles, or as a ready bit that no access cycle preceded. A broken self-exclusion in the response cycle shows as a sole requester being served every second cycle rather than every third. A lost read flag shows as nonzero read data returned with a write's ready.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACCESS = 2'd1,
    PH_RESP   = 2'd2
  } phase_e;
endpackage

// File: rtl/shmem_rr_pick.sv
module shmem_rr_pick #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int off = 0; off < N; off++) begin
      if (!any && req[(int'(ptr) + off) % N]) begin
        any = 1'b1;
        idx = IW'((int'(ptr) + off) % N);
      end
    end
  end
endmodule

// File: rtl/shmem_rr_seq.sv
module shmem_rr_seq
  import shmem_pkg::*;
#(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  cli_cs,
  input  logic          acc_rd,
  output phase_e        phase_q,
  output logic [IW-1:0] gnt_q,
  output logic          rd_q
);
  logic [IW-1:0] ptr_q;
  logic [N-1:0]  served_oh;
  logic [N-1:0]  req_eff;
  logic          pick_any;
  logic [IW-1:0] pick_idx;

  function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] i);
    return (int'(i) == N - 1) ? '0 : IW'(int'(i) + 1);
  endfunction

  always_comb begin
    served_oh = '0;
    if (phase_q == PH_RESP) served_oh[gnt_q] = 1'b1;
    req_eff = (phase_q == PH_ACCESS) ? '0 : (cli_cs & ~served_oh);
  end

  shmem_rr_pick #(.N(N)) u_pick (
    .req (req_eff),
    .ptr (ptr_q),
    .any (pick_any),
    .idx (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      gnt_q   <= '0;
      ptr_q   <= '0;
      rd_q    <= 1'b0;
    end else begin
      case (phase_q)
        PH_ACCESS: begin
          phase_q <= PH_RESP;
          rd_q    <= acc_rd;
        end
        PH_IDLE, PH_RESP: begin
          if (pick_any) begin
            phase_q <= PH_ACCESS;
            gnt_q   <= pick_idx;
            ptr_q   <= next_idx(pick_idx);
          end else begin
            phase_q <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_access_after_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && |cli_cs) |=> (phase_q == PH_ACCESS));

  assert_ptr_after_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACCESS) |-> (ptr_q == next_idx(gnt_q)));

  assert_no_self_regrant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RESP && |(cli_cs & ~served_oh)) |=>
      (phase_q == PH_ACCESS && gnt_q != $past(gnt_q)));

  assert_ptr_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && cli_cs == '0) |=> $stable(ptr_q));
endmodule

// File: rtl/shmem_port_mux.sv
module shmem_port_mux
  import shmem_pkg::*;
#(
  parameter int N  = 3,
  parameter int AW = 16,
  parameter int DW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  phase_e               phase_q,
  input  logic [IW-1:0]        gnt_q,
  input  logic                 rd_q,
  input  logic [N-1:0]         cli_rd,
  input  logic [N-1:0]         cli_wr,
  input  logic [N-1:0][AW-1:0] cli_addr,
  input  logic [N-1:0][DW-1:0] cli_wdata,
  output logic [N-1:0][DW-1:0] cli_rdata,
  output logic [N-1:0]         cli_rdy,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 mem_cs,
  output logic                 mem_rd,
  output logic                 mem_wr
);
  always_comb begin
    mem_cs    = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (phase_q == PH_ACCESS) begin
      mem_cs    = 1'b1;
      mem_rd    = cli_rd[gnt_q];
      mem_wr    = cli_wr[gnt_q];
      mem_addr  = cli_addr[gnt_q];
      mem_wdata = cli_wdata[gnt_q];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_resp
    assign cli_rdy[i]   = (phase_q == PH_RESP) && (gnt_q == IW'(i));
    assign cli_rdata[i] = (cli_rdy[i] && rd_q) ? mem_rdata : '0;
  end

  assert_single_inflight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs |=> !mem_cs);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs |-> (!mem_rd && !mem_wr));

  assert_rdy_after_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs |=> $onehot(cli_rdy));

  assert_rdy_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cli_rdy));

  assert_rdy_has_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|cli_rdy) |-> $past(mem_cs));
endmodule

// File: rtl/shmem_rr_ctrl.sv
module shmem_rr_ctrl
  import shmem_pkg::*;
#(
  parameter int N  = 3,
  parameter int AW = 16,
  parameter int DW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         cli_cs,
  input  logic [N-1:0]         cli_rd,
  input  logic [N-1:0]         cli_wr,
  input  logic [N-1:0][AW-1:0] cli_addr,
  input  logic [N-1:0][DW-1:0] cli_wdata,
  output logic [N-1:0][DW-1:0] cli_rdata,
  output logic [N-1:0]         cli_rdy,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 mem_cs,
  output logic                 mem_rd,
  output logic                 mem_wr
);
  phase_e        phase_q;
  logic [IW-1:0] gnt_q;
  logic          rd_q;

  shmem_rr_seq #(.N(N)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cli_cs  (cli_cs),
    .acc_rd  (mem_rd),
    .phase_q (phase_q),
    .gnt_q   (gnt_q),
    .rd_q    (rd_q)
  );

  shmem_port_mux #(.N(N), .AW(AW), .DW(DW)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_q   (phase_q),
    .gnt_q     (gnt_q),
    .rd_q      (rd_q),
    .cli_rd    (cli_rd),
    .cli_wr    (cli_wr),
    .cli_addr  (cli_addr),
    .cli_wdata (cli_wdata),
    .cli_rdata (cli_rdata),
    .cli_rdy   (cli_rdy),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_cs    (mem_cs),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!mem_cs && cli_rdy == '0));
endmodule

// File: tb/shmem_rr_ctrl_tb.sv
module shmem_rr_ctrl_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        cli_cs = '0, cli_rd = '0, cli_wr = '0;
  logic [2:0][15:0]  cli_addr = '0, cli_wdata = '0;
  logic [2:0][15:0]  cli_rdata;
  logic [2:0]        cli_rdy;
  logic [15:0]       mem_addr, mem_wdata, mem_rdata;
  logic              mem_cs, mem_rd, mem_wr;
  logic [15:0]       bmem [256];
  int                n_chk = 0, n_fail = 0;
  bit                done = 0;

  always #5 clk = ~clk;

  shmem_rr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cli_cs(cli_cs), .cli_rd(cli_rd), .cli_wr(cli_wr),
    .cli_addr(cli_addr), .cli_wdata(cli_wdata), .cli_rdata(cli_rdata), .cli_rdy(cli_rdy),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_cs(mem_cs), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  initial begin
    for (int a = 0; a < 256; a++) bmem[a] = (16'(a) * 16'h0101) ^ 16'h5A00;
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (mem_cs) begin
      if (mem_wr) bmem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= bmem[mem_addr[7:0]];
    end
  end

  typedef struct packed {
    logic [2:0] mask;
    logic [1:0] cnt;
    logic [1:0] o0, o1, o2;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'b001, 2'd1, 2'd0, 2'd0, 2'd0},
    '{3'b111, 2'd3, 2'd1, 2'd2, 2'd0},
    '{3'b101, 2'd2, 2'd2, 2'd0, 2'd0},
    '{3'b110, 2'd2, 2'd1, 2'd2, 2'd0},
    '{3'b011, 2'd2, 2'd0, 2'd1, 2'd0},
    '{3'b111, 2'd3, 2'd2, 2'd0, 2'd1},
    '{3'b010, 2'd1, 2'd1, 2'd0, 2'd0},
    '{3'b101, 2'd2, 2'd2, 2'd0, 2'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic run_vec(input int k);
    vec_t v = VECS[k];
    logic [2:0] pending = v.mask;
    int served = 0;
    logic [1:0] exp_o;
    for (int i = 0; i < 3; i++) begin
      cli_cs[i] = v.mask[i];
      cli_rd[i] = 1'b1;
      cli_wr[i] = 1'b0;
      cli_addr[i] = 16'h0040 + 16'(k * 4 + i);
    end
    for (int cyc = 0; cyc < 20 && pending != 0; cyc++) begin
      @(negedge clk);
      // R8: ready never appears for a client that is not waiting
      chk((cli_rdy & ~pending) == 0, "R8 rdy for non-waiting client", 32'(cli_rdy), 32'(pending));
      for (int i = 0; i < 3; i++) begin
        if (cli_rdy[i] && pending[i]) begin
          exp_o = (served == 0) ? v.o0 : (served == 1) ? v.o1 : v.o2;
          chk(2'(i) == exp_o, "R6 R7 service order", 32'(i), 32'(exp_o));
          chk(cli_rdata[i] == bmem[cli_addr[i][7:0]], "R3 read data", 32'(cli_rdata[i]),
              32'(bmem[cli_addr[i][7:0]]));
          cli_cs[i] = 1'b0;
          pending[i] = 1'b0;
          served++;
        end
      end
    end
    chk(served == int'(v.cnt), "R6 served count", 32'(served), 32'(v.cnt));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1;
    // R1: reset state
    chk(!mem_cs && !mem_rd && !mem_wr, "R1 mem strobes in reset", {mem_cs, mem_rd, mem_wr}, 0);
    chk(cli_rdy == 0 && cli_rdata == 0, "R1 client outputs in reset", 32'(cli_rdy), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_cs && cli_rdy == 0, "R1 quiet after reset", {mem_cs, cli_rdy}, 0);

    for (int k = 0; k < 8; k++) run_vec(k);

    // R2 / R4: write by client 2
    cli_rd = '0; cli_wr = 3'b100; cli_addr[2] = 16'h0020; cli_wdata[2] = 16'hBEEF; cli_cs = 3'b100;
    @(negedge clk);
    chk(mem_cs && mem_wr && !mem_rd, "R2 write access strobes", {mem_cs, mem_wr, mem_rd}, 3'b110);
    chk(mem_addr == 16'h0020, "R2 address steered", 32'(mem_addr), 32'h20);
    chk(mem_wdata == 16'hBEEF, "R2 write data steered", 32'(mem_wdata), 32'hBEEF);
    @(negedge clk);
    chk(cli_rdy == 3'b100, "R4 write ready", 32'(cli_rdy), 32'h4);
    chk(cli_rdata[2] == 0, "R4 write rdata zero", 32'(cli_rdata[2]), 0);
    chk(!mem_cs, "R5 no back-to-back access", 32'(mem_cs), 0);
    cli_cs = '0; cli_wr = '0;
    @(negedge clk);

    // R3: read back by client 0
    cli_rd = 3'b001; cli_addr[0] = 16'h0020; cli_cs = 3'b001;
    @(negedge clk);
    chk(mem_cs && mem_rd && !mem_wr && mem_addr == 16'h0020, "R2 read access", {mem_cs, mem_rd, mem_wr}, 3'b110);
    @(negedge clk);
    chk(cli_rdy == 3'b001 && cli_rdata[0] == 16'hBEEF, "R3 read returns written data", 32'(cli_rdata[0]), 32'hBEEF);
    chk(cli_rdata[1] == 0 && cli_rdata[2] == 0, "R4 other rdata zero", 32'({cli_rdata[1], cli_rdata[2]}), 0);
    cli_cs = '0;
    repeat (2) @(negedge clk);

    // R5: sole requester holding cs
    cli_rd = 3'b010; cli_addr[1] = 16'h0011; cli_cs = 3'b010;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(mem_cs == (k % 3 == 0), "R5 sole requester spacing", 32'(mem_cs), 32'(k % 3 == 0));
    end
    cli_cs = '0;
    repeat (2) @(negedge clk);

    // R8: client 0 holds cs, must wait for 1 and 2 (pointer reset to 0)
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    cli_rd = 3'b111; cli_cs = 3'b111;
    cli_addr[0] = 16'h0001; cli_addr[1] = 16'h0002; cli_addr[2] = 16'h0003;
    begin
      int got = 0;
      logic [1:0] exp_seq [4] = '{2'd0, 2'd1, 2'd2, 2'd0};
      for (int cyc = 0; cyc < 30 && got < 4; cyc++) begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
          if (cli_rdy[i] && got < 4) begin
            chk(2'(i) == exp_seq[got], "R8 no starvation order", 32'(i), 32'(exp_seq[got]));
            if (i != 0) cli_cs[i] = 1'b0;
            got++;
          end
        end
      end
      chk(got == 4, "R8 turns completed", 32'(got), 4);
    end
    cli_cs = '0;
    repeat (3) @(negedge clk);

    // R9: async reset mid-access
    cli_rd = '0; cli_wr = 3'b100; cli_addr[2] = 16'h0030; cli_cs = 3'b100;
    @(negedge clk);
    chk(mem_cs, "R9 access started", 32'(mem_cs), 1);
    rst_n = 1'b0;
    #1;
    chk(!mem_cs && !mem_wr && cli_rdy == 0, "R9 async clear", {mem_cs, mem_wr, cli_rdy}, 0);
    cli_cs = '0; cli_wr = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_cs && cli_rdy == 0, "R9 idle after reset", {mem_cs, cli_rdy}, 0);

    finish_run();
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end
endmodule